// File: doc/BRIEF.md
# Micro-op Group Packer

The packer sits between the instruction decoders and the out-of-order scheduler. Each cycle it builds one group of exactly four micro-op slots. The micro-ops come from one of two sources, and the two are never mixed in one group:

- **Short mode** takes the oldest one or two short instructions. Each short instruction carries one or two micro-ops.
- **Vector mode** takes a single instruction carrying one to four micro-ops.

Slots that no micro-op fills hold a configurable NOP encoding. An instruction whose expansion exceeds four micro-ops is not expanded here. It is consumed, marked for the microcode sequencer, and its group carries NOPs only.

The group sits in an output register that the scheduler drains under a ready/valid handshake. The per-instruction consume strobes are combinational. They fire only in a cycle in which the output register is able to take a new group, so a stalled scheduler freezes both the group and the decoder queue.

Top module: `uop_grp_packer`

## Requirements
- R1: When `vd_valid_i` is 1, vector mode is selected. Only `take_vd_o` may fire, and both `take_sd_o` bits stay 0 whatever the short inputs are.
- R2: When `vd_valid_i` is 0 and `sd_valid_i[0]` is 1, `take_sd_o[0]` fires. `take_sd_o[1]` fires with it only if `sd_valid_i[1]` is 1 and `sd1_vec_i` is 0. A set `sd1_vec_i` means the second instruction needs vector mode and waits. `take_sd_o[1]` never fires without `take_sd_o[0]`.
- R3: In short mode the micro-op count of each short instruction is `cnt+1` (cnt 0 gives 1, cnt 1 gives 2). The first instruction's micro-ops fill slots from slot 0 in index order. The second instruction's micro-ops follow directly after them.
- R4: In vector mode the count is `vd_cnt_i+1` (1 to 4). Entry k of `vd_uop_i` lands in slot k.
- R5: Every slot not filled under R3 or R4 holds `NOP_UOP`. Slot k of the group is bits `[k*UOP_W +: UOP_W]` of `grp_uop_o`.
- R6: A vector instruction with `vd_mcode_i` set is consumed. It yields a valid group with `grp_mcode_o` = 1 and all four slots equal to `NOP_UOP`.
- R7: A cycle in which no instruction is consumed loads an invalid, all-NOP group. `grp_valid_o` is then 0 in the following cycle, unless the register is held under R8.
- R8: While `grp_valid_o` is 1 and `grp_ready_i` is 0, no consume strobe fires, and the group and `grp_mcode_o` stay unchanged.
- R9: After reset `grp_valid_o` and `grp_mcode_o` are 0 and all slots are `NOP_UOP`. A group consumed in cycle n appears on the outputs from cycle n+1. Reset is asynchronous.
- R10: When `grp_valid_o` is 0, instructions are consumed and loaded even though `grp_ready_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_valid_i | input | 2 | Short instruction valid, bit 0 oldest |
| sd1_vec_i | input | 1 | Second short instruction needs vector mode |
| sd0_cnt_i | input | 1 | First short instruction micro-op count minus one |
| sd1_cnt_i | input | 1 | Second short instruction micro-op count minus one |
| sd0_uop_i | input | 2*UOP_W | First short instruction micro-ops |
| sd1_uop_i | input | 2*UOP_W | Second short instruction micro-ops |
| vd_valid_i | input | 1 | Vector instruction valid (oldest) |
| vd_cnt_i | input | 2 | Vector micro-op count minus one |
| vd_mcode_i | input | 1 | Vector instruction needs microcode |
| vd_uop_i | input | 4*UOP_W | Vector micro-ops |
| grp_ready_i | input | 1 | Scheduler accepts the group |
| take_sd_o | output | 2 | Short instruction consumed |
| take_vd_o | output | 1 | Vector instruction consumed |
| grp_valid_o | output | 1 | Group valid |
| grp_mcode_o | output | 1 | Group hands off to microcode |
| grp_uop_o | output | 4*UOP_W | Four micro-op slots |

## Verification
The bench builds the packer with `UOP_W` = 12 and `NOP_UOP` = 12'hFFF. Padding then cannot be mistaken for the default all-zero value or for any payload, which uses tags 12'h1xx and 12'h2xx. These tags identify each micro-op by its source and index. A misplaced slot, a wrong count or a missing pad therefore shows up directly in the compared group value.

// File: rtl/uop_pack_pkg.sv
package uop_pack_pkg;
  localparam int unsigned GRP_SLOTS = 4;
  localparam int unsigned SD_UOPS   = 2;
  localparam int unsigned CNT_W     = $clog2(GRP_SLOTS + 1);

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_SHORT = 2'd1,
    MODE_VEC   = 2'd2
  } pack_mode_e;
endpackage

// File: rtl/uop_mode_sel.sv
module uop_mode_sel
  import uop_pack_pkg::*;
(
  input  logic [1:0]  sd_valid_i,
  input  logic        sd1_vec_i,
  input  logic        vd_valid_i,
  input  logic        accept_i,
  output pack_mode_e  mode_o,
  output logic [1:0]  take_sd_o,
  output logic        take_vd_o
);
  // vector decoder holds the oldest instruction when valid
  always_comb begin
    if (vd_valid_i)         mode_o = MODE_VEC;
    else if (sd_valid_i[0]) mode_o = MODE_SHORT;
    else                    mode_o = MODE_IDLE;
  end

  always_comb begin
    take_vd_o    = accept_i && (mode_o == MODE_VEC);
    take_sd_o[0] = accept_i && (mode_o == MODE_SHORT);
    take_sd_o[1] = take_sd_o[0] && sd_valid_i[1] && !sd1_vec_i;
  end

  always_comb begin
    a_r2_pair_order: assert (!take_sd_o[1] || take_sd_o[0]);
  end
endmodule

// File: rtl/uop_slot_pack.sv
module uop_slot_pack
  import uop_pack_pkg::*;
#(
  parameter int unsigned      UOP_W   = 16,
  parameter logic [UOP_W-1:0] NOP_UOP = '0
) (
  input  pack_mode_e                             mode_i,
  input  logic                                   take1_i,
  input  logic                                   sd0_cnt_i,
  input  logic                                   sd1_cnt_i,
  input  logic [SD_UOPS-1:0][UOP_W-1:0]          sd0_uop_i,
  input  logic [SD_UOPS-1:0][UOP_W-1:0]          sd1_uop_i,
  input  logic [1:0]                             vd_cnt_i,
  input  logic                                   vd_mcode_i,
  input  logic [GRP_SLOTS-1:0][UOP_W-1:0]        vd_uop_i,
  output logic [GRP_SLOTS-1:0][UOP_W-1:0]        slot_o,
  output logic                                   mcode_o
);
  logic [CNT_W-1:0] n0, n1, nv;

  always_comb begin
    n0 = {{(CNT_W-1){1'b0}}, sd0_cnt_i} + CNT_W'(1);
    n1 = take1_i ? ({{(CNT_W-1){1'b0}}, sd1_cnt_i} + CNT_W'(1)) : '0;
    nv = vd_mcode_i ? '0 : ({{(CNT_W-2){1'b0}}, vd_cnt_i} + CNT_W'(1));
  end

  assign mcode_o = (mode_i == MODE_VEC) && vd_mcode_i;

  logic [UOP_W-1:0] slot_w [GRP_SLOTS];

  for (genvar g = 0; g < GRP_SLOTS; g++) begin : g_slot
    localparam logic [CNT_W-1:0] SI = CNT_W'(g);
    logic [CNT_W-1:0] rel;
    always_comb begin
      rel       = SI - n0;
      slot_w[g] = NOP_UOP;
      unique case (mode_i)
        MODE_VEC: begin
          if (SI < nv) slot_w[g] = vd_uop_i[g];
        end
        MODE_SHORT: begin
          if (SI < n0)                    slot_w[g] = sd0_uop_i[SI[0]];
          else if (rel < n1)              slot_w[g] = sd1_uop_i[rel[0]];
        end
        default: slot_w[g] = NOP_UOP;
      endcase
    end
    assign slot_o[g] = slot_w[g];
  end
endmodule

// File: rtl/uop_grp_reg.sv
module uop_grp_reg
  import uop_pack_pkg::*;
#(
  parameter int unsigned      UOP_W   = 16,
  parameter logic [UOP_W-1:0] NOP_UOP = '0
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              valid_i,
  input  logic                              mcode_i,
  input  logic [GRP_SLOTS-1:0][UOP_W-1:0]   slot_i,
  input  logic                              ready_i,
  output logic                              accept_o,
  output logic                              valid_o,
  output logic                              mcode_o,
  output logic [GRP_SLOTS-1:0][UOP_W-1:0]   slot_o
);
  logic                             valid_q, mcode_q;
  logic [GRP_SLOTS-1:0][UOP_W-1:0]  slot_q;

  assign accept_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      mcode_q <= 1'b0;
      slot_q  <= {GRP_SLOTS{NOP_UOP}};
    end else if (accept_o) begin
      valid_q <= valid_i;
      mcode_q <= mcode_i;
      slot_q  <= slot_i;
    end
  end

  assign valid_o = valid_q;
  assign mcode_o = mcode_q;
  assign slot_o  = slot_q;

  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(slot_o) && $stable(mcode_o));
  a_r6_mcode_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcode_o |-> valid_o);
endmodule

// File: rtl/uop_grp_packer.sv
module uop_grp_packer
  import uop_pack_pkg::*;
#(
  parameter int unsigned      UOP_W   = 16,
  parameter logic [UOP_W-1:0] NOP_UOP = '0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0]                   sd_valid_i,
  input  logic                         sd1_vec_i,
  input  logic                         sd0_cnt_i,
  input  logic                         sd1_cnt_i,
  input  logic [1:0][UOP_W-1:0]        sd0_uop_i,
  input  logic [1:0][UOP_W-1:0]        sd1_uop_i,
  input  logic                         vd_valid_i,
  input  logic [1:0]                   vd_cnt_i,
  input  logic                         vd_mcode_i,
  input  logic [3:0][UOP_W-1:0]        vd_uop_i,
  input  logic                         grp_ready_i,
  output logic [1:0]                   take_sd_o,
  output logic                         take_vd_o,
  output logic                         grp_valid_o,
  output logic                         grp_mcode_o,
  output logic [3:0][UOP_W-1:0]        grp_uop_o
);
  pack_mode_e                       mode;
  logic                             accept;
  logic                             pk_mcode;
  logic [GRP_SLOTS-1:0][UOP_W-1:0]  pk_slot;

  uop_mode_sel i_mode_sel (
    .sd_valid_i (sd_valid_i),
    .sd1_vec_i  (sd1_vec_i),
    .vd_valid_i (vd_valid_i),
    .accept_i   (accept),
    .mode_o     (mode),
    .take_sd_o  (take_sd_o),
    .take_vd_o  (take_vd_o)
  );

  uop_slot_pack #(.UOP_W(UOP_W), .NOP_UOP(NOP_UOP)) i_slot_pack (
    .mode_i     (mode),
    .take1_i    (take_sd_o[1]),
    .sd0_cnt_i  (sd0_cnt_i),
    .sd1_cnt_i  (sd1_cnt_i),
    .sd0_uop_i  (sd0_uop_i),
    .sd1_uop_i  (sd1_uop_i),
    .vd_cnt_i   (vd_cnt_i),
    .vd_mcode_i (vd_mcode_i),
    .vd_uop_i   (vd_uop_i),
    .slot_o     (pk_slot),
    .mcode_o    (pk_mcode)
  );

  uop_grp_reg #(.UOP_W(UOP_W), .NOP_UOP(NOP_UOP)) i_grp_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (mode != MODE_IDLE),
    .mcode_i  (pk_mcode),
    .slot_i   (pk_slot),
    .ready_i  (grp_ready_i),
    .accept_o (accept),
    .valid_o  (grp_valid_o),
    .mcode_o  (grp_mcode_o),
    .slot_o   (grp_uop_o)
  );

  a_r1_mode_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_vd_o |-> take_sd_o == 2'b00);
  a_r8_no_take_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o && !grp_ready_i |-> !take_vd_o && take_sd_o == 2'b00);
  a_r9_take_gives_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_vd_o || take_sd_o[0] |=> grp_valid_o);
  a_r6_mcode_all_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_mcode_o |-> grp_uop_o == {GRP_SLOTS{NOP_UOP}});
  a_r10_empty_accepts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grp_valid_o && vd_valid_i |-> take_vd_o);
endmodule

// File: tb/test_uop_grp_packer.sv
`timescale 1ns/1ps
module test_uop_grp_packer;
  localparam int unsigned      UW  = 12;
  localparam logic [UW-1:0]    NOP = 12'hFFF;
  localparam int               NV  = 12;

  // [61:60] sd_valid [59] sd1_vec [58] sd1_cnt [57] sd0_cnt [56] vd_valid
  // [55:54] vd_cnt [53] mcode [52:50] take{vd,sd1,sd0} [49] gv [48] gm [47:0] slots
  localparam logic [61:0] VEC [NV] = '{
    {2'b01,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0, 3'b001,1'b1,1'b0, 12'hFFF,12'hFFF,12'hFFF,12'h100},
    {2'b11,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0, 3'b011,1'b1,1'b0, 12'h111,12'h110,12'h101,12'h100},
    {2'b11,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0, 3'b011,1'b1,1'b0, 12'hFFF,12'h111,12'h110,12'h100},
    {2'b11,1'b0,1'b0,1'b1,1'b0,2'd0,1'b0, 3'b011,1'b1,1'b0, 12'hFFF,12'h110,12'h101,12'h100},
    {2'b11,1'b1,1'b1,1'b1,1'b0,2'd0,1'b0, 3'b001,1'b1,1'b0, 12'hFFF,12'hFFF,12'h101,12'h100},
    {2'b10,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0, 3'b000,1'b0,1'b0, 12'hFFF,12'hFFF,12'hFFF,12'hFFF},
    {2'b00,1'b0,1'b0,1'b0,1'b1,2'd3,1'b0, 3'b100,1'b1,1'b0, 12'h203,12'h202,12'h201,12'h200},
    {2'b00,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0, 3'b100,1'b1,1'b0, 12'hFFF,12'hFFF,12'hFFF,12'h200},
    {2'b11,1'b0,1'b1,1'b1,1'b1,2'd2,1'b0, 3'b100,1'b1,1'b0, 12'hFFF,12'h202,12'h201,12'h200},
    {2'b00,1'b0,1'b0,1'b0,1'b1,2'd3,1'b1, 3'b100,1'b1,1'b1, 12'hFFF,12'hFFF,12'hFFF,12'hFFF},
    {2'b01,1'b0,1'b0,1'b1,1'b0,2'd0,1'b0, 3'b001,1'b1,1'b0, 12'hFFF,12'hFFF,12'h101,12'h100},
    {2'b00,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0, 3'b000,1'b0,1'b0, 12'hFFF,12'hFFF,12'hFFF,12'hFFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sd_valid = '0;
  logic sd1_vec = 0, sd0_cnt = 0, sd1_cnt = 0, vd_valid = 0, vd_mcode = 0, rdy = 1;
  logic [1:0] vd_cnt = '0;
  logic [1:0][UW-1:0] sd0_uop = {12'h101, 12'h100};
  logic [1:0][UW-1:0] sd1_uop = {12'h111, 12'h110};
  logic [3:0][UW-1:0] vd_uop  = {12'h203, 12'h202, 12'h201, 12'h200};
  logic [1:0] take_sd;
  logic take_vd, gv, gm;
  logic [3:0][UW-1:0] guop;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  uop_grp_packer #(.UOP_W(UW), .NOP_UOP(NOP)) i_uop_grp_packer (
    .clk_i(clk), .rst_ni(rst_n), .sd_valid_i(sd_valid), .sd1_vec_i(sd1_vec),
    .sd0_cnt_i(sd0_cnt), .sd1_cnt_i(sd1_cnt), .sd0_uop_i(sd0_uop), .sd1_uop_i(sd1_uop),
    .vd_valid_i(vd_valid), .vd_cnt_i(vd_cnt), .vd_mcode_i(vd_mcode), .vd_uop_i(vd_uop),
    .grp_ready_i(rdy), .take_sd_o(take_sd), .take_vd_o(take_vd), .grp_valid_o(gv),
    .grp_mcode_o(gm), .grp_uop_o(guop));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [61:0] v);
    sd_valid = v[61:60]; sd1_vec = v[59]; sd1_cnt = v[58]; sd0_cnt = v[57];
    vd_valid = v[56]; vd_cnt = v[55:54]; vd_mcode = v[53];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] allnop;
    allnop = {4{NOP}};
    #10;
    // R9 reset state
    chk(gv == 1'b0 && gm == 1'b0, "R9 reset flags", {62'd0, gv, gm}, 64'd0);
    chk(guop == allnop, "R9 reset slots", 64'(guop), 64'(allnop));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      #1;
      chk({take_vd, take_sd} == VEC[i][52:50], $sformatf("R1 R2 take vec%0d", i),
          64'({take_vd, take_sd}), 64'(VEC[i][52:50]));
      @(negedge clk);
      chk({gv, gm} == VEC[i][49:48], $sformatf("R6 R7 R9 flags vec%0d", i),
          64'({gv, gm}), 64'(VEC[i][49:48]));
      chk(guop == VEC[i][47:0], $sformatf("R3 R4 R5 slots vec%0d", i),
          64'(guop), 64'(VEC[i][47:0]));
    end

    // R10: empty register loads while ready is low
    rdy = 1'b0;
    apply(VEC[0]);
    #1;
    chk(take_sd == 2'b01, "R10 take while empty", 64'(take_sd), 64'd1);
    @(negedge clk);
    chk(gv && guop == VEC[0][47:0], "R10 group loaded", 64'(guop), 64'(VEC[0][47:0]));

    // R8: stalled, new vector input must wait
    apply(VEC[6]);
    #1;
    chk({take_vd, take_sd} == 3'b000, "R8 no take stalled", 64'({take_vd, take_sd}), 64'd0);
    @(negedge clk);
    chk(gv && guop == VEC[0][47:0], "R8 group held", 64'(guop), 64'(VEC[0][47:0]));
    chk({take_vd, take_sd} == 3'b000, "R8 still no take", 64'({take_vd, take_sd}), 64'd0);
    rdy = 1'b1;
    #1;
    chk(take_vd == 1'b1, "R8 take on ready", 64'(take_vd), 64'd1);
    @(negedge clk);
    chk(gv && guop == VEC[6][47:0], "R8 R9 next group", 64'(guop), 64'(VEC[6][47:0]));

    // R9: asynchronous reset mid-cycle
    apply(VEC[11]);
    #2;
    rst_n = 1'b0;
    #1;
    chk(gv == 1'b0 && guop == allnop, "R9 async reset", 64'(guop), 64'(allnop));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule